// File: doc/BRIEF.md
# External Clock Qualifier and Glitch-Free Source Switch

This block decides whether a high-speed clock arriving from outside the chip can be trusted, and hands the system master clock over to it without producing a truncated pulse. A free-running Gray-coded counter runs on the external clock. The local oscillator domain samples that counter through a synchronizer. Every fixed window of local cycles, the local domain takes the difference between two samples as the number of external edges seen in that window. The external clock is only declared usable when this number lands inside a narrow lower/upper bracket for several windows in a row. A single bad window withdraws the status, so an erratic clock, for example one supplied by a neighbour that is powering down, is rejected.

Software drives a select input that asks for the external source, and it reads two status outputs: whether the external clock is qualified, and which source currently drives the output. The request only takes effect while the external clock is qualified. If qualification is lost while the external clock is driving the output, the block falls back to the local oscillator on its own. The output multiplexer has two branches, one per clock. Each branch turns its own enable off on its own clock's falling edge, and it only turns on after it has seen, through a two-stage synchronizer, that the other branch is off. Reset always leaves the local clock driving the output.

Top module: `extclk_guard`

## Requirements
- R1: While reset is asserted and right after it, `clk_out` follows `clk_loc`, and `ext_good` and `src_ext` read 0.
- R2: Over each window of WIN local cycles, the number of external clock cycles is counted, and a window is in range when that count is between LO and HI inclusive (defaults 64, 76, 84; a 4.0 ns external period against 5.0 ns local gives 80).
- R3: The first window after reset only sets the baseline. `ext_good` rises only at the end of the STREAK-th consecutive in-range window (default 3).
- R4: One out-of-range window clears `ext_good` at the end of that window.
- R5: An external clock that stops at either level is judged not good, and the output returns to the local clock.
- R6: An external clock whose half periods vary at random over a wide spread never becomes good.
- R7: `sel_ext` = 1 has no effect while `ext_good` is 0. The output keeps the local period and `src_ext` stays 0.
- R8: With `sel_ext` = 1 and `ext_good` = 1, the output switches to the external clock, and `src_ext` reads 1 once the handover is complete.
- R9: Clearing `sel_ext` returns the output to the local clock, and `src_ext` returns to 0.
- R10: If `ext_good` drops while the external clock is selected, the output falls back to the local clock without software action.
- R11: Both branch enables are never on together, and during a handover no high or low pulse on `clk_out` is shorter than the shorter half period of the two clocks.
- R12: `ext_good` changes only at the end of a window, and `src_ext` = 1 implies the local branch is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_loc | input | 1 | Local oscillator clock; runs the judge and the status logic |
| clk_ext | input | 1 | External high-speed clock under test |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_ext | input | 1 | Software request to run from the external clock (1) or the local clock (0) |
| clk_out | output | 1 | Glitch-free multiplexed master clock |
| ext_good | output | 1 | External clock qualified (local domain) |
| src_ext | output | 1 | The external branch currently drives `clk_out` (local domain) |

## Verification
The hardest situation to reach is losing the external clock while it is the active source. In that state the external branch can no longer clock its own enable off, and the handover must still complete. The stimulus first qualifies and selects the external clock. It then freezes the generator in the middle of operation, and in a separate case speeds it out of bracket. In both cases it watches the output period return to the local value. Erratic behaviour comes from a seeded random half-period generator whose window counts stay out of bracket.

// File: rtl/extclk_guard_pkg.sv
`timescale 1ns/1ps
package extclk_guard_pkg;

  // Smallest synchronizer depth accepted anywhere in the block.
  localparam int MIN_SYNC = 2;

  // A window count is acceptable when it lies in [lo, hi].
  function automatic logic in_bracket(input int cnt, input int lo, input int hi);
    return (cnt >= lo) && (cnt <= hi);
  endfunction

endpackage

// File: rtl/extclk_bit_sync.sv
`timescale 1ns/1ps
module extclk_bit_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/extclk_gray_tally.sv
`timescale 1ns/1ps
module extclk_gray_tally #(
  parameter int CNT_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk_ext,
  input  logic             clk_loc,
  input  logic             rst_n,
  output logic [CNT_W-1:0] tally
);

  function automatic logic [CNT_W-1:0] bin_to_gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CNT_W-1:0] gray_to_bin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // External-domain run enable: reset asserted at once, released after SYNC_N ext edges.
  logic x_run;
  extclk_bit_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_xrun (
    .clk(clk_ext), .arst_n(rst_n), .d(1'b1), .q(x_run)
  );

  logic [CNT_W-1:0] bin_q, gray_q, bin_nxt;
  assign bin_nxt = bin_q + 1'b1;

  always_ff @(posedge clk_ext or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (x_run) begin
      bin_q  <= bin_nxt;
      gray_q <= bin_to_gray(bin_nxt);
    end
  end

  // Local-domain capture of the Gray code: only one bit moves per ext edge.
  logic [CNT_W-1:0] stage_q [SYNC_N];

  always_ff @(posedge clk_loc or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_N; i++) stage_q[i] <= '0;
    end else begin
      for (int i = SYNC_N - 1; i > 0; i--) stage_q[i] <= stage_q[i-1];
      stage_q[0] <= gray_q;
    end
  end

  assign tally = gray_to_bin(stage_q[SYNC_N-1]);

endmodule

// File: rtl/extclk_window_judge.sv
`timescale 1ns/1ps
module extclk_window_judge
  import extclk_guard_pkg::*;
#(
  parameter int WIN    = 64,
  parameter int CNT_W  = 8,
  parameter int LO     = 76,
  parameter int HI     = 84,
  parameter int STREAK = 3
) (
  input  logic             clk_loc,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tally,
  output logic             good,
  output logic             win_end,
  output logic             in_rng
);

  localparam int WC_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int SK_W = $clog2(STREAK + 1);
  localparam logic [WC_W-1:0] LAST   = WC_W'(WIN - 1);
  localparam logic [SK_W-1:0] SK_MAX = SK_W'(STREAK);
  localparam logic [SK_W-1:0] SK_ARM = SK_W'(STREAK - 1);

  logic [WC_W-1:0]  wcnt_q;
  logic [CNT_W-1:0] prev_q, delta;
  logic [SK_W-1:0]  streak_q;
  logic             primed_q, good_q;

  // Edges seen since the previous window boundary (modulo counter width).
  assign delta   = tally - prev_q;
  assign win_end = (wcnt_q == LAST);
  assign in_rng  = primed_q & in_bracket(int'(delta), LO, HI);

  always_ff @(posedge clk_loc or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q   <= '0;
      prev_q   <= '0;
      streak_q <= '0;
      primed_q <= 1'b0;
      good_q   <= 1'b0;
    end else begin
      wcnt_q <= win_end ? '0 : wcnt_q + 1'b1;
      if (win_end) begin
        prev_q   <= tally;
        primed_q <= 1'b1;
        if (in_rng) begin
          if (streak_q != SK_MAX) streak_q <= streak_q + 1'b1;
          if (streak_q >= SK_ARM) good_q <= 1'b1;
        end else begin
          streak_q <= '0;
          good_q   <= 1'b0;
        end
      end
    end
  end

  assign good = good_q;

endmodule

// File: rtl/extclk_clock_switch.sv
`timescale 1ns/1ps
module extclk_clock_switch #(
  parameter int SYNC_N = 2
) (
  input  logic clk_loc,
  input  logic clk_ext,
  input  logic rst_n,
  input  logic want_ext,
  input  logic kill_ext,
  output logic clk_out,
  output logic en_loc,
  output logic en_ext,
  output logic src_ext
);

  // The external branch is held cleared while that clock is not qualified,
  // because a dead clock cannot step its own enable down.
  logic xb_arst_n;
  assign xb_arst_n = rst_n & ~kill_ext;

  // ---------------- local branch ----------------
  logic en_ext_seen, loc_arm;

  extclk_bit_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_ext_seen (
    .clk(clk_loc), .arst_n(rst_n), .d(en_ext), .q(en_ext_seen)
  );

  always_ff @(posedge clk_loc or negedge rst_n) begin
    if (!rst_n) loc_arm <= 1'b1;
    else        loc_arm <= ~want_ext & ~en_ext_seen;
  end

  always_ff @(negedge clk_loc or negedge rst_n) begin
    if (!rst_n) en_loc <= 1'b1;
    else        en_loc <= loc_arm;
  end

  // ---------------- external branch ----------------
  logic want_seen, en_loc_seen, ext_arm;

  extclk_bit_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_want_seen (
    .clk(clk_ext), .arst_n(xb_arst_n), .d(want_ext), .q(want_seen)
  );

  extclk_bit_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_loc_seen (
    .clk(clk_ext), .arst_n(xb_arst_n), .d(en_loc), .q(en_loc_seen)
  );

  always_ff @(posedge clk_ext or negedge xb_arst_n) begin
    if (!xb_arst_n) ext_arm <= 1'b0;
    else            ext_arm <= want_seen & ~en_loc_seen;
  end

  always_ff @(negedge clk_ext or negedge xb_arst_n) begin
    if (!xb_arst_n) en_ext <= 1'b0;
    else            en_ext <= ext_arm;
  end

  assign clk_out = (clk_loc & en_loc) | (clk_ext & en_ext);
  assign src_ext = en_ext_seen;

endmodule

// File: rtl/extclk_guard.sv
`timescale 1ns/1ps
module extclk_guard
  import extclk_guard_pkg::*;
#(
  parameter int WIN    = 64,
  parameter int CNT_W  = 8,
  parameter int LO     = 76,
  parameter int HI     = 84,
  parameter int STREAK = 3,
  parameter int SYNC_N = 2
) (
  input  logic clk_loc,
  input  logic clk_ext,
  input  logic rst_n,
  input  logic sel_ext,
  output logic clk_out,
  output logic ext_good,
  output logic src_ext
);

  localparam int SYNC_USE = (SYNC_N < MIN_SYNC) ? MIN_SYNC : SYNC_N;

  // Named internal events, brought out for the bound checker.
  logic [CNT_W-1:0] tally;
  logic             win_end, in_rng;
  logic             want_q, kill_q;
  logic             en_loc, en_ext;

  extclk_gray_tally #(.CNT_W(CNT_W), .SYNC_N(SYNC_USE)) u_tally (
    .clk_ext(clk_ext), .clk_loc(clk_loc), .rst_n(rst_n), .tally(tally)
  );

  extclk_window_judge #(
    .WIN(WIN), .CNT_W(CNT_W), .LO(LO), .HI(HI), .STREAK(STREAK)
  ) u_judge (
    .clk_loc(clk_loc), .rst_n(rst_n), .tally(tally),
    .good(ext_good), .win_end(win_end), .in_rng(in_rng)
  );

  // Request is honoured only while qualified; loss of qualification clears it.
  always_ff @(posedge clk_loc or negedge rst_n) begin
    if (!rst_n) begin
      want_q <= 1'b0;
      kill_q <= 1'b1;
    end else begin
      want_q <= sel_ext & ext_good;
      kill_q <= ~ext_good;
    end
  end

  extclk_clock_switch #(.SYNC_N(SYNC_USE)) u_switch (
    .clk_loc(clk_loc), .clk_ext(clk_ext), .rst_n(rst_n),
    .want_ext(want_q), .kill_ext(kill_q),
    .clk_out(clk_out), .en_loc(en_loc), .en_ext(en_ext), .src_ext(src_ext)
  );

endmodule

// File: rtl/extclk_guard_chk.sv
`timescale 1ns/1ps
module extclk_guard_chk (
  input logic clk_loc,
  input logic rst_n,
  input logic ext_good,
  input logic src_ext,
  input logic win_end,
  input logic in_rng,
  input logic en_loc,
  input logic en_ext
);

  p_excl_r11: assert property (@(posedge clk_loc) disable iff (!rst_n)
    !(en_loc && en_ext));

  p_src_loc_off_r12: assert property (@(posedge clk_loc) disable iff (!rst_n)
    src_ext |-> !en_loc);

  p_streak_r3: assert property (@(posedge clk_loc) disable iff (!rst_n)
    $rose(ext_good) |-> $past(win_end && in_rng));

  p_drop_r4: assert property (@(posedge clk_loc) disable iff (!rst_n)
    (win_end && !in_rng) |=> !ext_good);

  p_win_only_r12: assert property (@(posedge clk_loc) disable iff (!rst_n)
    (ext_good != $past(ext_good)) |-> $past(win_end));

  p_fallback_r10: assert property (@(posedge clk_loc) disable iff (!rst_n)
    !ext_good |=> !en_ext);

endmodule

bind extclk_guard extclk_guard_chk i_chk (
  .clk_loc(clk_loc), .rst_n(rst_n), .ext_good(ext_good), .src_ext(src_ext),
  .win_end(win_end), .in_rng(in_rng), .en_loc(en_loc), .en_ext(en_ext)
);

// File: tb/test_extclk_guard.sv
`timescale 1ns/1ps
module test_extclk_guard;

  localparam int  WIN    = 64;
  localparam int  LO     = 76;
  localparam int  HI     = 84;
  localparam int  STREAK = 3;
  localparam real TLOC   = 5.0;

  logic clk_loc = 1'b0;
  logic clk_ext = 1'b0;
  logic rst_n   = 1'b0;
  logic sel_ext = 1'b0;
  logic clk_out, ext_good, src_ext;

  int  n_chk = 0, n_err = 0;
  real ext_half = 2.0;
  bit  ext_run = 1'b1, ext_jit = 1'b0, saw_good = 1'b0;
  real t_pos = -1.0, t_neg = -1.0, min_pulse = 1.0e9, last_per = 0.0;

  extclk_guard i_extclk_guard (
    .clk_loc(clk_loc), .clk_ext(clk_ext), .rst_n(rst_n), .sel_ext(sel_ext),
    .clk_out(clk_out), .ext_good(ext_good), .src_ext(src_ext)
  );

  always #2.5 clk_loc = ~clk_loc;

  initial begin : ext_gen
    real h;
    forever begin
      if (ext_run) begin
        h = ext_jit ? 0.8 + real'($urandom % 300) / 100.0 : ext_half;
        #(h) clk_ext = ~clk_ext;
      end else #1;
    end
  end

  always @(posedge clk_out) begin
    if (t_pos > 0.0) last_per = $realtime - t_pos;
    if (t_neg > 0.0 && ($realtime - t_neg) < min_pulse) min_pulse = $realtime - t_neg;
    t_pos = $realtime;
  end
  always @(negedge clk_out) begin
    if (t_pos > 0.0 && ($realtime - t_pos) < min_pulse) min_pulse = $realtime - t_pos;
    t_neg = $realtime;
  end
  always @(posedge clk_loc) if (ext_good) saw_good = 1'b1;

  // Expected behaviour, restated from the requirements.
  function automatic int exp_count(real half);
    return $rtoi(WIN * TLOC / (2.0 * half));
  endfunction
  function automatic bit exp_ok(real half);
    int c;
    c = exp_count(half);
    return (c >= LO) && (c <= HI);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_per(string req, real exp);
    int a, e;
    a = $rtoi(last_per * 1000.0);
    e = $rtoi(exp * 1000.0);
    n_chk++;
    if (a < e - 30 || a > e + 30) begin
      n_err++;
      $display("FAIL %s actual %0d ps expected %0d ps", req, a, e);
    end
  endtask

  task automatic wait_loc(int n);
    repeat (n) @(posedge clk_loc);
    #1;
  endtask

  task automatic settle(real half);
    ext_half = half;
    wait_loc((STREAK + 2) * WIN + 8);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin : watchdog
    #(100000 * TLOC);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual running expected done");
    finish_run();
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    // R1: reset state
    wait_loc(10);
    chk("R1 good in reset", int'(ext_good), 0);
    chk("R1 src in reset", int'(src_ext), 0);
    chk("R1 clk_out high phase", int'(clk_out), int'(clk_loc));
    @(negedge clk_loc); #1;
    chk("R1 clk_out low phase", int'(clk_out), int'(clk_loc));
    rst_n = 1'b1;
    wait_loc(2);
    chk("R1 clk_out after reset", int'(clk_out), int'(clk_loc));

    // R3: baseline window plus STREAK in-range windows
    wait_loc(STREAK * WIN + WIN / 2 - 2);
    chk("R3 not yet good", int'(ext_good), 0);
    wait_loc(WIN);
    chk("R3 R2 good after streak", int'(ext_good), int'(exp_ok(2.0)));

    // R8 / R11: switch to external
    @(negedge clk_loc);
    min_pulse = 1.0e9;
    sel_ext = 1'b1;
    wait_loc(60);
    chk("R8 src_ext", int'(src_ext), 1);
    chk_per("R8 ext period", 2.0 * ext_half);
    chk("R11 no runt to ext", int'(min_pulse >= 1.95), 1);

    // R9 / R11: back to local
    @(negedge clk_loc);
    min_pulse = 1.0e9;
    sel_ext = 1'b0;
    wait_loc(60);
    chk("R9 src_ext cleared", int'(src_ext), 0);
    chk_per("R9 local period", TLOC);
    chk("R11 no runt to loc", int'(min_pulse >= 1.95), 1);

    // R2: bracket with slow, near-edge and fast clocks
    settle(2.2);
    chk("R2 slow rejected", int'(ext_good), int'(exp_ok(2.2)));
    settle(2.05);
    chk("R2 near edge accepted", int'(ext_good), int'(exp_ok(2.05)));
    // R4: one bad window drops the status
    ext_half = 1.8;
    wait_loc(2 * WIN + 8);
    chk("R4 fast drops within window", int'(ext_good), int'(exp_ok(1.8)));

    // R7: selection ignored while not good
    @(negedge clk_loc);
    sel_ext = 1'b1;
    wait_loc(60);
    chk("R7 src stays local", int'(src_ext), 0);
    chk_per("R7 local period kept", TLOC);
    settle(2.0);
    wait_loc(60);
    chk("R8 held select takes effect", int'(src_ext), 1);

    // R10: lose qualification while selected
    ext_half = 1.8;
    wait_loc(2 * WIN + 60);
    chk("R10 good lost", int'(ext_good), 0);
    chk("R10 src fell back", int'(src_ext), 0);
    chk_per("R10 local period", TLOC);

    // R5: stop the external clock while it drives the output
    settle(2.0);
    wait_loc(60);
    chk("R5 precondition on ext", int'(src_ext), 1);
    ext_run = 1'b0;
    wait_loc(2 * WIN + 60);
    chk("R5 stopped not good", int'(ext_good), 0);
    chk("R5 src local", int'(src_ext), 0);
    chk_per("R5 local period", TLOC);

    // R6: erratic clock never qualifies
    ext_jit = 1'b1;
    ext_run = 1'b1;
    wait_loc(WIN);
    saw_good = 1'b0;
    wait_loc(10 * WIN);
    chk("R6 erratic never good", int'(saw_good), 0);
    chk("R6 src local", int'(src_ext), 0);
    ext_jit = 1'b0;

    // Random in-range periods keep qualification
    for (int k = 0; k < 3; k++) begin
      real h;
      h = 1.95 + real'($urandom % 11) / 100.0;
      settle(h);
      chk("R2 random in-range", int'(ext_good), int'(exp_ok(h)));
    end
    wait_loc(60);
    chk("R8 random src ext", int'(src_ext), 1);

    // R1: reset in the middle of external operation
    @(negedge clk_loc);
    rst_n = 1'b0;
    wait_loc(4);
    chk("R1 mid-run reset good", int'(ext_good), 0);
    chk("R1 mid-run reset src", int'(src_ext), 0);
    chk("R1 mid-run clk_out", int'(clk_out), int'(clk_loc));
    finish_run();
  end

endmodule